// File: doc/BRIEF.md
# Link Capability and Status Generator

This block sits in the configuration logic of a downstream port of a serial point-to-point interconnect. It builds the read-only link capability words from three build-time settings: the largest lane count the port supports, the fastest speed it supports, and its port number. It also drives the target-speed field of the second link control word, which starts at the port's top speed.

At run time it watches the lane count and speed reported by the attached device, together with a presence flag. From these it keeps a live link status word. Each reported field is limited to what the port itself can do. A field reported as zero falls back to one lane or to the slowest speed. With nothing attached, the status simply mirrors the port's own capability.

A two-state machine tracks presence. ST_EMPTY moves to ST_LINKED on transition T_ATTACH, when the presence flag is high. ST_LINKED moves back to ST_EMPTY on transition T_DETACH, when the flag is low. In ST_EMPTY the status takes the capability fields. In ST_LINKED it takes the limited device fields. Speed codes are 1 = 2.5 GT/s, 2 = 5 GT/s, 3 = 8 GT/s and 4 = 16 GT/s. Widths are plain lane counts.

Top module: `link_status_gen`

## Requirements
- R1: The capability word holds the top speed code in bits 3:0, the top lane count in bits 9:4 and the port number in bits 31:24. Bits 20 and 21 are set only as R2 and R3 say, and every other bit is zero. The word never changes.
- R2: Capability bit 21 (bandwidth-notification capable) is 1 exactly when the top lane count exceeds 1 or the top speed code exceeds 1.
- R3: When the top speed code exceeds 1, capability bit 20 (link-active reporting capable) is 1, status bit 13 (link active) is 1, and the target-speed output equals the top speed code. Otherwise all three are 0.
- R4: In the second capability word, bit n stands for speed code n. Bits 3:1 are 1 when the top speed code exceeds 2. Bit 4 is 1 when the top speed code exceeds 3. All other bits are 0.
- R5: While reset is held, the state is ST_EMPTY and the status width (bits 9:4) and speed (bits 3:0) equal the capability's width and speed fields.
- R6: With the presence flag low, the status width and speed fields copy the capability fields, whatever the device width and speed inputs carry.
- R7: With a device present, a reported width above the top lane count is shown as the top lane count.
- R8: With a device present, a reported speed code above the top speed code is shown as the top speed code.
- R9: With a device present, a reported width of 0 is shown as 1, and a reported speed code of 0 is shown as 1.
- R10: With a device present, a nonzero reported value within the port's limit is shown unchanged.
- R11: The status fields change on the first rising clock edge after an input change and not before. Status bits 15:14 and 12:10 are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_present | input | 1 | High when a device is attached |
| dev_width | input | 6 | Lane count reported by the device |
| dev_speed | input | 4 | Speed code reported by the device |
| link_cap | output | 32 | Link capability word |
| link_cap2 | output | 32 | Second link capability word (supported-speed vector) |
| link_sta | output | 16 | Live link status word |
| link_tls | output | 4 | Target-speed field of the second link control word |

## Verification
The bench drives widths and speeds just above, exactly at and far beyond the port's limits (for example 63 lanes and speed code 15). A design that compared the wrong way or without enough bits would pass these values through unlimited. Zero fields check the fallback; a design without it would show a zero-lane or zero-speed link. Detach steps that carry in-range device values catch a design that ignores presence, because such a design would show the device values instead of the capability. Right after every drive, the bench confirms that the status still holds its old value, which catches a design that reacts combinationally.

// File: rtl/link_pkg.sv
package link_pkg;

    localparam int WID_W = 6;
    localparam int SPD_W = 4;

    localparam int SPD_2G5 = 1;
    localparam int SPD_5G  = 2;
    localparam int SPD_8G  = 3;
    localparam int SPD_16G = 4;

    localparam int CAP_DLLARC_BIT = 20;
    localparam int CAP_LBN_BIT    = 21;
    localparam int STA_DLLA_BIT   = 13;

    typedef enum logic {
        ST_EMPTY  = 1'b0,
        ST_LINKED = 1'b1
    } link_state_e;

endpackage

// File: rtl/link_field_clamp.sv
module link_field_clamp #(
    parameter int W    = 6,
    parameter int MAXV = 8,
    parameter int DFLT = 1
) (
    input  logic [W-1:0] raw,
    output logic [W-1:0] clamped
);
    localparam logic [W-1:0] MAX_L  = W'(MAXV);
    localparam logic [W-1:0] DFLT_L = W'(DFLT);

    always_comb begin
        if (raw == '0)
            clamped = DFLT_L;
        else if (raw > MAX_L)
            clamped = MAX_L;
        else
            clamped = raw;
    end
endmodule

// File: rtl/link_cap_build.sv
module link_cap_build
    import link_pkg::*;
#(
    parameter int MAX_WIDTH = 8,
    parameter int MAX_SPEED = 3,
    parameter int PORT_NUM  = 5
) (
    output logic [31:0]      cap_word,
    output logic [31:0]      cap2_word,
    output logic [SPD_W-1:0] tls,
    output logic             dll_active
);
    localparam logic FAST_LINK = (MAX_SPEED > SPD_2G5);
    localparam logic WIDE_LINK = (MAX_WIDTH > 1);

    always_comb begin
        cap_word                 = '0;
        cap_word[3:0]            = SPD_W'(MAX_SPEED);
        cap_word[9:4]            = WID_W'(MAX_WIDTH);
        cap_word[31:24]          = 8'(PORT_NUM);
        cap_word[CAP_DLLARC_BIT] = FAST_LINK;
        cap_word[CAP_LBN_BIT]    = FAST_LINK | WIDE_LINK;
    end

    // bit n of the supported-speed vector stands for speed code n
    for (genvar i = 0; i < 32; i++) begin : g_vec
        if (i >= SPD_2G5 && i <= SPD_8G) begin : g_base
            assign cap2_word[i] = (MAX_SPEED > SPD_5G);
        end else if (i == SPD_16G) begin : g_top
            assign cap2_word[i] = (MAX_SPEED > SPD_8G);
        end else begin : g_zero
            assign cap2_word[i] = 1'b0;
        end
    end

    assign tls        = FAST_LINK ? SPD_W'(MAX_SPEED) : '0;
    assign dll_active = FAST_LINK;
endmodule

// File: rtl/link_status_gen.sv
module link_status_gen
    import link_pkg::*;
#(
    parameter int MAX_WIDTH = 8,
    parameter int MAX_SPEED = 3,
    parameter int PORT_NUM  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dev_present,
    input  logic [WID_W-1:0] dev_width,
    input  logic [SPD_W-1:0] dev_speed,
    output logic [31:0]      link_cap,
    output logic [31:0]      link_cap2,
    output logic [15:0]      link_sta,
    output logic [SPD_W-1:0] link_tls
);
    localparam logic [WID_W-1:0] CAP_WID = WID_W'(MAX_WIDTH);
    localparam logic [SPD_W-1:0] CAP_SPD = SPD_W'(MAX_SPEED);

    link_state_e      st_q, st_d;
    logic [WID_W-1:0] wid_q, wid_d, wid_lim;
    logic [SPD_W-1:0] spd_q, spd_d, spd_lim;
    logic             dll_act;

    link_cap_build #(
        .MAX_WIDTH(MAX_WIDTH),
        .MAX_SPEED(MAX_SPEED),
        .PORT_NUM (PORT_NUM)
    ) u_cap (
        .cap_word  (link_cap),
        .cap2_word (link_cap2),
        .tls       (link_tls),
        .dll_active(dll_act)
    );

    link_field_clamp #(.W(WID_W), .MAXV(MAX_WIDTH), .DFLT(1)) u_wid_lim (
        .raw    (dev_width),
        .clamped(wid_lim)
    );

    link_field_clamp #(.W(SPD_W), .MAXV(MAX_SPEED), .DFLT(SPD_2G5)) u_spd_lim (
        .raw    (dev_speed),
        .clamped(spd_lim)
    );

    // next state: T_ATTACH / T_DETACH
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_EMPTY:  if (dev_present)  st_d = ST_LINKED;
            ST_LINKED: if (!dev_present) st_d = ST_EMPTY;
            default:   st_d = ST_EMPTY;
        endcase
    end

    // status fields selected by the state being entered
    always_comb begin
        wid_d = CAP_WID;
        spd_d = CAP_SPD;
        unique case (st_d)
            ST_EMPTY: begin
                wid_d = CAP_WID;
                spd_d = CAP_SPD;
            end
            ST_LINKED: begin
                wid_d = wid_lim;
                spd_d = spd_lim;
            end
            default: begin
                wid_d = CAP_WID;
                spd_d = CAP_SPD;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_EMPTY;
            wid_q <= CAP_WID;
            spd_q <= CAP_SPD;
        end else begin
            st_q  <= st_d;
            wid_q <= wid_d;
            spd_q <= spd_d;
        end
    end

    assign link_sta = {2'b00, dll_act, 3'b000, wid_q, spd_q};
endmodule

// File: rtl/link_status_chk.sv
module link_status_chk
    import link_pkg::*;
#(
    parameter int MAX_WIDTH = 8,
    parameter int MAX_SPEED = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dev_present,
    input logic [WID_W-1:0] dev_width,
    input logic [SPD_W-1:0] dev_speed,
    input logic [31:0]      link_cap,
    input logic [15:0]      link_sta
);
    localparam logic [WID_W-1:0] MW = WID_W'(MAX_WIDTH);
    localparam logic [SPD_W-1:0] MS = SPD_W'(MAX_SPEED);

    AST_CAP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(link_cap)); // R1

    AST_EMPTY_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(dev_present) |-> (link_sta[9:4] == link_cap[9:4] && link_sta[3:0] == link_cap[3:0])); // R6

    AST_WIDTH_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        link_sta[9:4] <= MW); // R7

    AST_SPEED_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        link_sta[3:0] <= MS); // R8

    AST_NO_ZERO_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        (link_sta[9:4] != '0 && link_sta[3:0] != '0)); // R9

    AST_WIDTH_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dev_present) && $past(dev_width) != '0 && $past(dev_width) <= MW)
        |-> link_sta[9:4] == $past(dev_width)); // R10

    AST_SPEED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dev_present) && $past(dev_speed) != '0 && $past(dev_speed) <= MS)
        |-> link_sta[3:0] == $past(dev_speed)); // R10

    AST_STA_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (link_sta[15:14] == 2'b00 && link_sta[12:10] == 3'b000)); // R11
endmodule

bind link_status_gen link_status_chk #(
    .MAX_WIDTH(MAX_WIDTH),
    .MAX_SPEED(MAX_SPEED)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dev_present(dev_present),
    .dev_width  (dev_width),
    .dev_speed  (dev_speed),
    .link_cap   (link_cap),
    .link_sta   (link_sta)
);

// File: tb/tb_link_status_gen.sv
module tb_link_status_gen;
    localparam int MW = 8;
    localparam int MS = 3;
    localparam int PN = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dev_present = 1'b0;
    logic [5:0]  dev_width = '0;
    logic [3:0]  dev_speed = '0;
    logic [31:0] link_cap, link_cap2;
    logic [15:0] link_sta;
    logic [3:0]  link_tls;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int    due;
        int    w;
        int    s;
        string tag;
    } exp_t;
    exp_t sb[$];
    int last_w, last_s;

    always #10 clk = ~clk;

    link_status_gen #(.MAX_WIDTH(MW), .MAX_SPEED(MS), .PORT_NUM(PN)) dut (
        .clk(clk), .rst_n(rst_n), .dev_present(dev_present),
        .dev_width(dev_width), .dev_speed(dev_speed),
        .link_cap(link_cap), .link_cap2(link_cap2),
        .link_sta(link_sta), .link_tls(link_tls)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic int lim(input int raw, input int mx);
        if (raw == 0) return 1;
        if (raw > mx) return mx;
        return raw;
    endfunction

    // driver: apply inputs at the falling edge, queue the expected result
    task automatic drive(input bit p, input int w, input int s, input string tag);
        exp_t e;
        @(negedge clk);
        dev_present = p;
        dev_width = 6'(w);
        dev_speed = 4'(s);
        e.due = cyc + 1;
        e.w = p ? lim(w, MW) : MW;
        e.s = p ? lim(s, MS) : MS;
        e.tag = tag;
        sb.push_back(e);
        #1;
        check("R11 no early change width", int'(link_sta[9:4]), last_w);
        check("R11 no early change speed", int'(link_sta[3:0]), last_s);
        last_w = e.w;
        last_s = e.s;
    endtask

    // monitor: compare after each rising edge
    always @(posedge clk) begin
        cyc++;
        #5;
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            check({e.tag, " width"}, int'(link_sta[9:4]), e.w);
            check({e.tag, " speed"}, int'(link_sta[3:0]), e.s);
            check("R3 link active bit", int'(link_sta[13]), 1);
            check("R11 reserved bits", int'({link_sta[15:14], link_sta[12:10]}), 0);
        end
    end

    initial begin
        #4_000_000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        last_w = MW;
        last_s = MS;
        repeat (3) @(posedge clk);
        #5;
        check("R5 reset width", int'(link_sta[9:4]), MW);
        check("R5 reset speed", int'(link_sta[3:0]), MS);
        check("R1 cap word", int'(link_cap), (PN << 24) | (1 << 21) | (1 << 20) | (MW << 4) | MS);
        check("R2 bandwidth notify bit", int'(link_cap[21]), 1);
        check("R3 active reporting bit", int'(link_cap[20]), 1);
        check("R3 target speed", int'(link_tls), MS);
        check("R4 speed vector", int'(link_cap2), 32'h0000_000E);
        @(negedge clk);
        rst_n = 1'b1;

        drive(1'b0, 16, 4, "R6 absent ignores inputs");
        drive(1'b1, 4, 2, "R10 in range");
        drive(1'b1, 16, 3, "R7 wide clamp");
        drive(1'b1, 2, 4, "R8 fast clamp");
        drive(1'b1, 0, 0, "R9 zero fallback");
        drive(1'b1, 0, 2, "R9 zero width only");
        drive(1'b1, 8, 3, "R10 at limit");
        drive(1'b1, 1, 1, "R10 minimum");
        drive(1'b1, 63, 15, "R7 R8 extreme");
        drive(1'b0, 2, 1, "R6 detach");
        drive(1'b0, 5, 2, "R6 absent hold");
        drive(1'b1, 3, 2, "R10 reattach");
        drive(1'b1, 9, 0, "R7 R9 mixed");
        repeat (3) @(posedge clk);
        #6;
        check("R1 cap word stable", int'(link_cap), (PN << 24) | (1 << 21) | (1 << 20) | (MW << 4) | MS);
        check("scoreboard drained", sb.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule